// File: doc/BRIEF.md
# Float Min/Max and Clamp Unit

This block takes two single-precision (IEEE-754 binary32) operands and returns either the smaller or the larger of them. It can first strip the sign from both operands, so that it compares magnitudes. It handles NaN operands in one of two ways: it either ignores a lone NaN and returns the other operand, or it lets the NaN through. Whichever value is selected then passes through an output modifier. The modifier either leaves the value as it is or clamps it into one of three ranges, and each clamp range replaces a NaN with a fixed constant.

The unit is one scalar lane with a single register stage. An operation issued with `valid_i` high appears on `result_o` one clock later, with `valid_o` raised. When `valid_i` is low, the output register keeps its value.

Top module: `fmm_unit`

## Requirements
- R1: `op_i[2]` picks max (1) or min (0). For two ordinary values, the result is the operand whose value is larger or smaller, returned bit for bit.
- R2: When `op_i[0]`=0 and exactly one operand is NaN, the result is the other operand.
- R3: When `op_i[0]`=1 and exactly one operand is NaN, the result is that NaN operand, with its payload kept. Its sign is cleared only if R5 applies.
- R4: When both operands are NaN, the value selected before the modifier is 0x7FC00000, whatever `op_i` is.
- R5: When `op_i[1]`=1, the sign bit of both operands is cleared before the comparison, so the result is the magnitude of the chosen operand.
- R6: -0.0 orders below +0.0, so min(-0,+0)=0x80000000 and max(-0,+0)=0x00000000.
- R7: When `mod_i`=0, the selected value reaches the output unchanged, infinities included.
- R8: When `mod_i`=1, the result is max(x, +0.0). A NaN becomes 0x00000000, and so does -0.0.
- R9: When `mod_i`=2, the result is clamped into [-1.0, 1.0] and a NaN becomes 0xBF800000. -0.0 stays -0.0.
- R10: When `mod_i`=3, the result is clamped into [+0.0, 1.0]. A NaN and -0.0 both become 0x00000000.
- R11: `valid_o` equals `valid_i` delayed by one clock. `result_o` shows the result of the input from the cycle before, and it holds its value through cycles where `valid_i` is low.
- R12: While reset is active, `valid_o` is 0 and `result_o` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operation valid |
| op_i | input | 3 | Operation: bit 2 selects max, bit 1 selects absolute value, bit 0 selects NaN propagation |
| mod_i | input | 2 | Output modifier: 0 none, 1 clamp at zero, 2 clamp to [-1,1], 3 clamp to [0,1] |
| a_i | input | 32 | First binary32 operand |
| b_i | input | 32 | Second binary32 operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Registered binary32 result |

## Verification
The ordering check uses operand pairs with mixed signs, two negatives, infinities and the two signed zeros. These tell a comparison on the raw bit patterns apart from a true ordered comparison. The NaN patterns include a positive NaN, a negative NaN with its own payload, and two NaNs together. Each pattern runs under both NaN policies and under the absolute-value form, which separates the cases "return the other operand", "propagate with payload", "propagate with cleared sign" and "canonical NaN". Each clamp mode gets values below, inside and above its range, plus a NaN and -0.0, so that every NaN constant and the handling of negative zero are checked for that mode.

// File: rtl/fmm_pkg.sv
package fmm_pkg;
  parameter int unsigned EXP_W  = 8;
  parameter int unsigned MAN_W  = 23;
  localparam int unsigned DATA_W = 1 + EXP_W + MAN_W;

  typedef logic [DATA_W-1:0] fword_t;

  typedef enum logic [1:0] {
    MOD_NONE   = 2'd0,
    MOD_POS    = 2'd1,
    MOD_SNORM  = 2'd2,
    MOD_UNORM  = 2'd3
  } mod_e;

  // op bit positions
  localparam int unsigned OP_PROP_BIT = 0;
  localparam int unsigned OP_ABS_BIT  = 1;
  localparam int unsigned OP_MAX_BIT  = 2;

  localparam fword_t F_POS_ZERO = '0;
  localparam fword_t F_ONE      = {1'b0, 1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
  localparam fword_t F_NEG_ONE  = {1'b1, 1'b0, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};
  localparam fword_t F_QNAN     = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic f_is_nan(input fword_t x);
    return (&x[DATA_W-2 -: EXP_W]) && (|x[MAN_W-1:0]);
  endfunction

  // Monotonic unsigned key: -0 below +0, negatives reversed
  function automatic fword_t f_key(input fword_t x);
    return x[DATA_W-1] ? ~x : (x | {1'b1, {(DATA_W-1){1'b0}}});
  endfunction
endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
(
  input  fword_t x_i,
  input  logic   abs_i,
  output fword_t val_o,
  output fword_t key_o,
  output logic   nan_o
);
  always_comb begin
    val_o = x_i;
    if (abs_i) val_o[DATA_W-1] = 1'b0;
    nan_o = f_is_nan(val_o);
    key_o = f_key(val_o);
  end
endmodule

// File: rtl/fmm_select.sv
module fmm_select
  import fmm_pkg::*;
(
  input  fword_t a_i,
  input  fword_t b_i,
  input  fword_t a_key_i,
  input  fword_t b_key_i,
  input  logic   a_nan_i,
  input  logic   b_nan_i,
  input  logic   is_max_i,
  input  logic   prop_i,
  output fword_t res_o,
  output logic   res_nan_o
);
  logic a_lt;
  assign a_lt = a_key_i < b_key_i;

  always_comb begin
    if (a_nan_i && b_nan_i)      res_o = F_QNAN;
    else if (a_nan_i)            res_o = prop_i ? a_i : b_i;
    else if (b_nan_i)            res_o = prop_i ? b_i : a_i;
    else if (is_max_i)           res_o = a_lt ? b_i : a_i;
    else                         res_o = a_lt ? a_i : b_i;
    res_nan_o = (a_nan_i && b_nan_i) || (prop_i && (a_nan_i || b_nan_i));
  end
endmodule

// File: rtl/fmm_clamp.sv
module fmm_clamp
  import fmm_pkg::*;
(
  input  fword_t x_i,
  input  logic   nan_i,
  input  mod_e   mod_i,
  output fword_t y_o
);
  localparam fword_t KEY_ONE     = f_key(F_ONE);
  localparam fword_t KEY_NEG_ONE = f_key(F_NEG_ONE);

  fword_t key;
  logic   neg, above_one, below_neg_one;

  assign key           = f_key(x_i);
  assign neg           = x_i[DATA_W-1];
  assign above_one     = key > KEY_ONE;
  assign below_neg_one = key < KEY_NEG_ONE;

  always_comb begin
    unique case (mod_i)
      MOD_NONE:  y_o = x_i;
      MOD_POS:   y_o = (nan_i || neg) ? F_POS_ZERO : x_i;
      MOD_SNORM: begin
        if (nan_i || below_neg_one) y_o = F_NEG_ONE;
        else if (above_one)         y_o = F_ONE;
        else                        y_o = x_i;
      end
      default: begin
        if (nan_i || neg)   y_o = F_POS_ZERO;
        else if (above_one) y_o = F_ONE;
        else                y_o = x_i;
      end
    endcase
  end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        mod_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned N_OPS = 2;

  fword_t opnd [N_OPS];
  fword_t val  [N_OPS];
  fword_t key  [N_OPS];
  logic   nan  [N_OPS];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fmm_classify u_cls (
      .x_i   (opnd[g]),
      .abs_i (op_i[OP_ABS_BIT]),
      .val_o (val[g]),
      .key_o (key[g]),
      .nan_o (nan[g])
    );
  end

  fword_t sel_res, clamp_res;
  logic   sel_nan;

  fmm_select u_sel (
    .a_i       (val[0]),
    .b_i       (val[1]),
    .a_key_i   (key[0]),
    .b_key_i   (key[1]),
    .a_nan_i   (nan[0]),
    .b_nan_i   (nan[1]),
    .is_max_i  (op_i[OP_MAX_BIT]),
    .prop_i    (op_i[OP_PROP_BIT]),
    .res_o     (sel_res),
    .res_nan_o (sel_nan)
  );

  fmm_clamp u_clamp (
    .x_i   (sel_res),
    .nan_i (sel_nan),
    .mod_i (mod_e'(mod_i)),
    .y_o   (clamp_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= clamp_res;
    end
  end

  assert_valid_lat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_lat_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_one_nan_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[OP_PROP_BIT] && (nan[0] != nan[1])) |-> !f_is_nan(sel_res));
  assert_abs_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[OP_ABS_BIT]) |-> !sel_res[DATA_W-1]);
  assert_pos_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mod_i == 2'd1) |-> (!clamp_res[DATA_W-1] && !f_is_nan(clamp_res)));
  assert_snorm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mod_i == 2'd2) |-> (clamp_res[DATA_W-2:0] <= F_ONE[DATA_W-2:0]));
  assert_unorm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mod_i == 2'd3) |-> (clamp_res <= F_ONE));
endmodule

// File: tb/fmm_unit_tb.sv
module fmm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [1:0]  mod_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fmm_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .mod_i(mod_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .result_o(result_o)
  );

  // {req, op, mod, a, b, expected}
  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  op;
    logic [1:0]  md;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 3'd0, 2'd0, 32'h3F800000, 32'h40000000, 32'h3F800000}, // R1 min
    '{8'd1, 3'd4, 2'd0, 32'h3F800000, 32'h40000000, 32'h40000000}, // R1 max
    '{8'd1, 3'd0, 2'd0, 32'hC0000000, 32'h3F000000, 32'hC0000000}, // R1 mixed sign
    '{8'd1, 3'd4, 2'd0, 32'hC0000000, 32'hC0400000, 32'hC0000000}, // R1 two negatives
    '{8'd2, 3'd0, 2'd0, 32'h7FC00001, 32'h40000000, 32'h40000000}, // R2
    '{8'd2, 3'd4, 2'd0, 32'hBF800000, 32'hFFC00002, 32'hBF800000}, // R2
    '{8'd3, 3'd1, 2'd0, 32'h7FC00001, 32'h40000000, 32'h7FC00001}, // R3
    '{8'd3, 3'd5, 2'd0, 32'hBF800000, 32'hFFC00002, 32'hFFC00002}, // R3
    '{8'd3, 3'd3, 2'd0, 32'hFFC00002, 32'h3F800000, 32'h7FC00002}, // R3 abs
    '{8'd4, 3'd0, 2'd0, 32'h7FC00001, 32'hFFC00002, 32'h7FC00000}, // R4
    '{8'd4, 3'd5, 2'd0, 32'h7FC00001, 32'hFFC00002, 32'h7FC00000}, // R4
    '{8'd5, 3'd2, 2'd0, 32'hC0400000, 32'h40000000, 32'h40000000}, // R5 absmin
    '{8'd5, 3'd6, 2'd0, 32'hC0400000, 32'h40000000, 32'h40400000}, // R5 absmax
    '{8'd5, 3'd6, 2'd0, 32'hFF800000, 32'h3F800000, 32'h7F800000}, // R5 inf
    '{8'd6, 3'd0, 2'd0, 32'h80000000, 32'h00000000, 32'h80000000}, // R6
    '{8'd6, 3'd4, 2'd0, 32'h00000000, 32'h80000000, 32'h00000000}, // R6
    '{8'd7, 3'd0, 2'd0, 32'hFF800000, 32'h3F800000, 32'hFF800000}, // R7
    '{8'd8, 3'd4, 2'd1, 32'hC0000000, 32'hC0400000, 32'h00000000}, // R8
    '{8'd8, 3'd4, 2'd1, 32'h40400000, 32'h3F800000, 32'h40400000}, // R8
    '{8'd8, 3'd1, 2'd1, 32'h7FC00001, 32'h3F800000, 32'h00000000}, // R8 nan
    '{8'd8, 3'd0, 2'd1, 32'h80000000, 32'h00000000, 32'h00000000}, // R8 -0
    '{8'd9, 3'd4, 2'd2, 32'h40400000, 32'h3F800000, 32'h3F800000}, // R9
    '{8'd9, 3'd0, 2'd2, 32'hFF800000, 32'h00000000, 32'hBF800000}, // R9
    '{8'd9, 3'd0, 2'd2, 32'hBF000000, 32'h3F800000, 32'hBF000000}, // R9
    '{8'd9, 3'd1, 2'd2, 32'h7FC00001, 32'h3F800000, 32'hBF800000}, // R9 nan
    '{8'd9, 3'd0, 2'd2, 32'h80000000, 32'h00000000, 32'h80000000}, // R9 -0
    '{8'd10, 3'd0, 2'd3, 32'hBF000000, 32'h3F800000, 32'h00000000}, // R10
    '{8'd10, 3'd4, 2'd3, 32'h7F800000, 32'h00000000, 32'h3F800000}, // R10
    '{8'd10, 3'd0, 2'd3, 32'h3F000000, 32'h3F800000, 32'h3F000000}, // R10
    '{8'd10, 3'd5, 2'd3, 32'h7FC00001, 32'hFFC00002, 32'h00000000}  // R10 nan
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // R12 reset state, with inputs active
    valid_i = 1'b1; a_i = 32'h40000000; b_i = 32'h3F800000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 valid", {31'd0, valid_o}, 32'd0);
    check("R12 result", result_o, 32'd0);
    valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // table walk, back to back
    for (int i = 0; i < NV; i++) begin
      valid_i = 1'b1; op_i = VECS[i].op; mod_i = VECS[i].md;
      a_i = VECS[i].a; b_i = VECS[i].b;
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), result_o, VECS[i].exp);
      check($sformatf("R11 valid vec%0d", i), {31'd0, valid_o}, 32'd1);
    end

    // R11: idle hold
    valid_i = 1'b0; held = result_o;
    op_i = 3'd4; mod_i = 2'd0; a_i = 32'h40400000; b_i = 32'h3F800000;
    @(negedge clk);
    check("R11 idle valid", {31'd0, valid_o}, 32'd0);
    check("R11 hold", result_o, held);
    @(negedge clk);
    check("R11 hold2", result_o, held);

    // R11: one-cycle latency
    valid_i = 1'b1; op_i = 3'd0; a_i = 32'hC0000000; b_i = 32'h3F800000;
    #1;
    check("R11 before edge", {31'd0, valid_o}, 32'd0);
    check("R11 before edge result", result_o, held);
    @(negedge clk);
    valid_i = 1'b0;
    check("R11 after edge", result_o, 32'hC0000000);
    check("R11 after edge valid", {31'd0, valid_o}, 32'd1);
    @(negedge clk);
    check("R11 drop valid", {31'd0, valid_o}, 32'd0);

    // R12: reset mid-run clears output
    rst_n = 1'b0; #1;
    check("R12 async valid", {31'd0, valid_o}, 32'd0);
    check("R12 async result", result_o, 32'd0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule